// File: doc/BRIEF.md
# Heterogeneous Link Traffic Steering Unit

This block sits at the transmit end of one on-chip link that has three parallel wire sets of different widths. Lane 0 is a fast 8-bit set. Lane 1 is a 64-bit baseline set. Lane 2 is a 128-bit low-power set. Each message carries a kind, a criticality flag and a payload. The block classifies the message, picks a lane and queues it in that lane's FIFO. The lane then sends the payload as beats that are each as wide as the lane, and a receive stage rebuilds the payload.

Each lane takes a fixed number of cycles to move one beat. A lane starts its next beat only after the current beat has completed. A rebuilt message waits in its lane's holding register until the single output port takes it. The output port tags every delivered message with the lane it used. Messages on one lane arrive in the order they were issued. There is no ordering between lanes.

Kind encoding on `in_kind`: 0 = integer operand (64 bits), 1 = control code (8 bits), 2 = bursty bulk transfer (128 bits), 3 = general data (128 bits).

Top module: `link_steer`

## Requirements
- R1: A message goes to lane 0 if it is a control code, or if it is an operand whose bits 63..8 are all zero (value below 256). The delivered payload is then the low 8 bits.
- R2: A message that R1 does not route goes to lane 2 if it is a bulk transfer or its criticality flag is 0.
- R3: Every other message goes to lane 1. These are critical operands of 256 or more and critical general data.
- R4: The delivered payload is the input cut to the kind's width: 64 bits for an operand, 8 bits for a control code and 128 bits otherwise. All bits above that width are zero.
- R5: A 128-bit payload on lane 1 travels as two beats, low half first. It is rebuilt bit-exact.
- R6: An isolated message appears on `out_valid` 1 + LAT×beats cycles after the clock edge that accepts it, where LAT is 1 for lane 0, 2 for lane 1 and 3 for lane 2. That gives 2 cycles on lane 0, 3 on lane 1 (1 beat), 5 on lane 1 (2 beats) and 4 on lane 2.
- R7: Each lane FIFO holds 4 entries. When lane 0's FIFO is full, a critical message bound for lane 0 is sent on lane 1 instead.
- R8: Any other message whose lane FIFO is full is stalled by holding `in_ready` low. No accepted message is lost.
- R9: Messages that use the same lane are delivered in acceptance order.
- R10: `out_lane` gives the lane used (0, 1 or 2). At most one message is delivered per cycle. When several lanes are ready at once, the lower lane number goes first, and the others keep their messages.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A message is offered |
| in_ready | output | 1 | The offered message is taken at this edge |
| in_kind | input | 2 | Message kind (see encoding) |
| in_crit | input | 1 | 1 = critical, 0 = non-critical |
| in_data | input | 128 | Payload, zero-extended |
| out_valid | output | 1 | A rebuilt message is delivered this cycle |
| out_lane | output | 2 | Lane the message used |
| out_data | output | 128 | Rebuilt payload |

## Verification
The hardest cases to reach from the ports are lane 0's FIFO filling up and two lanes finishing in the same cycle.

- **Full FIFO:** lane 0 drains one message every two cycles, so the bench offers a message on every cycle. It does this with critical narrow operands to force the fallback to lane 1, and again with non-critical control codes to force stalls. It then checks the lane tag and the order of each delivered value.
- **Same-cycle completion:** the bench issues a lane 1 operand and, one cycle later, a lane 0 operand. Their latencies are 3 and 2 cycles, so both complete at the same edge. The bench checks that lane 0 is delivered one cycle before lane 1.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    LN_FAST = 2'd0,
    LN_BASE = 2'd1,
    LN_WIDE = 2'd2
  } lane_e;

  typedef enum logic [1:0] {
    K_OPND = 2'd0,
    K_CTRL = 2'd1,
    K_BULK = 2'd2,
    K_DATA = 2'd3
  } kind_e;

  localparam int NLANES = 3;
endpackage

// File: rtl/steer_classify.sv
module steer_classify
  import steer_pkg::*;
#(
  parameter int MSG_W    = 128,
  parameter int OPND_W   = 64,
  parameter int CTRL_W   = 8,
  parameter int NARROW_W = 8,
  parameter int LEN_W    = 8
) (
  input  logic [1:0]       kind,
  input  logic             crit,
  input  logic [MSG_W-1:0] data,
  output lane_e            pref,
  output logic             may_fallback,
  output logic [MSG_W-1:0] pay,
  output logic [LEN_W-1:0] len
);
  logic narrow_op;
  logic to_fast;
  logic [MSG_W-1:0] mask;

  always_comb begin
    narrow_op = (kind == K_OPND) && (data[OPND_W-1:NARROW_W] == '0);
    to_fast   = (kind == K_CTRL) || narrow_op;

    if (narrow_op)           len = LEN_W'(NARROW_W);
    else if (kind == K_OPND) len = LEN_W'(OPND_W);
    else if (kind == K_CTRL) len = LEN_W'(CTRL_W);
    else                     len = LEN_W'(MSG_W);

    mask = ~({MSG_W{1'b1}} << len);
    pay  = data & mask;

    if (to_fast)                        pref = LN_FAST;
    else if ((kind == K_BULK) || !crit) pref = LN_WIDE;
    else                                pref = LN_BASE;

    may_fallback = to_fast && crit;
  end
endmodule

// File: rtl/steer_fifo.sv
module steer_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign rdata = mem[rp_q];

  always_comb begin
    do_wr = wr && !full;
    do_rd = rd && !empty;
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/steer_lane.sv
module steer_lane #(
  parameter int MSG_W  = 128,
  parameter int BEAT_W = 8,
  parameter int LAT    = 1,
  parameter int DEPTH  = 4,
  parameter int LEN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [MSG_W-1:0] push_data,
  input  logic [LEN_W-1:0] push_len,
  output logic             full,
  output logic             hold_v,
  output logic [MSG_W-1:0] hold_data,
  input  logic             grant
);
  localparam int NBEAT_MAX = MSG_W / BEAT_W;
  localparam int NB_W      = $clog2(NBEAT_MAX + 1);
  localparam int LAT_W     = $clog2(LAT + 1);
  localparam int ENT_W     = NB_W + MSG_W;

  logic [NB_W-1:0]  push_nb;
  logic [ENT_W-1:0] q_rdata;
  logic             q_empty, pop;

  assign push_nb = NB_W'(({1'b0, push_len} + (LEN_W+1)'(BEAT_W - 1)) / (LEN_W+1)'(BEAT_W));

  steer_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .wr(push), .wdata({push_nb, push_data}),
    .rd(pop), .rdata(q_rdata), .full(full), .empty(q_empty)
  );

  logic             busy_q, busy_d;
  logic [MSG_W-1:0] sh_q, sh_d, acc_q, acc_d;
  logic [NB_W-1:0]  left_q, left_d, idx_q, idx_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             hv_q, hv_d;
  logic [MSG_W-1:0] hd_q, hd_d;
  logic             beat_done, last;

  assign hold_v    = hv_q;
  assign hold_data = hd_q;

  always_comb begin
    pop       = !busy_q && !q_empty;
    beat_done = busy_q && (lat_q == LAT_W'(1));
    last      = (left_q == NB_W'(1));
    busy_d = busy_q; sh_d = sh_q; acc_d = acc_q; left_d = left_q;
    idx_d  = idx_q;  lat_d = lat_q;
    hv_d   = hv_q && !grant;
    hd_d   = hd_q;
    if (pop) begin
      busy_d = 1'b1;
      sh_d   = q_rdata[MSG_W-1:0];
      left_d = q_rdata[ENT_W-1:MSG_W];
      idx_d  = '0;
      lat_d  = LAT_W'(LAT);
      acc_d  = '0;
    end else if (beat_done && (!last || !hv_q || grant)) begin
      acc_d[int'(idx_q)*BEAT_W +: BEAT_W] = sh_q[BEAT_W-1:0];
      sh_d   = sh_q >> BEAT_W;
      idx_d  = idx_q + 1'b1;
      left_d = left_q - 1'b1;
      lat_d  = LAT_W'(LAT);
      if (last) begin
        busy_d = 1'b0;
        hv_d   = 1'b1;
        hd_d   = acc_d;
      end
    end else if (busy_q && !beat_done) begin
      lat_d = lat_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sh_q <= '0; acc_q <= '0; left_q <= '0;
      idx_q  <= '0;   lat_q <= '0; hv_q <= 1'b0; hd_q <= '0;
    end else begin
      busy_q <= busy_d; sh_q <= sh_d; acc_q <= acc_d; left_q <= left_d;
      idx_q  <= idx_d;  lat_q <= lat_d; hv_q <= hv_d; hd_q <= hd_d;
    end
  end
endmodule

// File: rtl/link_steer.sv
module link_steer
  import steer_pkg::*;
#(
  parameter int MSG_W    = 128,
  parameter int OPND_W   = 64,
  parameter int CTRL_W   = 8,
  parameter int FAST_W   = 8,
  parameter int BASE_W   = 64,
  parameter int WIDE_W   = 128,
  parameter int LAT_FAST = 1,
  parameter int LAT_BASE = 2,
  parameter int LAT_WIDE = 3,
  parameter int DEPTH    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic             in_crit,
  input  logic [MSG_W-1:0] in_data,
  output logic             out_valid,
  output logic [1:0]       out_lane,
  output logic [MSG_W-1:0] out_data
);
  localparam int LEN_W = $clog2(MSG_W + 1);

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lane_e            pref, tgt;
  logic             may_fb;
  logic [MSG_W-1:0] pay;
  logic [LEN_W-1:0] len;

  steer_classify #(
    .MSG_W(MSG_W), .OPND_W(OPND_W), .CTRL_W(CTRL_W),
    .NARROW_W(FAST_W), .LEN_W(LEN_W)
  ) u_cls (
    .kind(in_kind), .crit(in_crit), .data(in_data),
    .pref(pref), .may_fallback(may_fb), .pay(pay), .len(len)
  );

  logic [NLANES-1:0] lane_full, lane_push, hold_v, grant;
  logic [MSG_W-1:0]  hold_data [NLANES];

  always_comb begin
    tgt = pref;
    if ((pref == LN_FAST) && lane_full[LN_FAST] && may_fb) tgt = LN_BASE;
    in_ready  = !lane_full[tgt];
    lane_push = '0;
    lane_push[tgt] = in_valid && in_ready;
  end

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int BW = (g == 0) ? FAST_W : (g == 1) ? BASE_W : WIDE_W;
    localparam int LT = (g == 0) ? LAT_FAST : (g == 1) ? LAT_BASE : LAT_WIDE;
    steer_lane #(
      .MSG_W(MSG_W), .BEAT_W(BW), .LAT(LT), .DEPTH(DEPTH), .LEN_W(LEN_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_int_n), .push(lane_push[g]),
      .push_data(pay), .push_len(len), .full(lane_full[g]),
      .hold_v(hold_v[g]), .hold_data(hold_data[g]), .grant(grant[g])
    );
  end

  always_comb begin
    grant     = hold_v & (~hold_v + 1'b1);
    out_valid = |hold_v;
    out_lane  = '0;
    out_data  = '0;
    for (int i = NLANES - 1; i >= 0; i--) begin
      if (grant[i]) begin
        out_lane = 2'(i);
        out_data = hold_data[i];
      end
    end
  end
endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
  parameter int MSG_W  = 128,
  parameter int FAST_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_kind,
  input logic             out_valid,
  input logic [1:0]       out_lane,
  input logic [MSG_W-1:0] out_data,
  input logic [2:0]       lane_full,
  input logic [2:0]       hold_v,
  input logic [2:0]       grant
);
  // R1
  fast_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_lane == 2'd0) |-> (out_data[MSG_W-1:FAST_W] == '0));

  // R10
  lane_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lane != 2'd3));

  // R8
  ctrl_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 2'd1 && !lane_full[0]) |-> in_ready);

  // R8
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (lane_full != 3'b000));

  // R10
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v[2] && !grant[2]) |=> hold_v[2]);

  // R10
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(grant));
endmodule

bind link_steer steer_chk #(.MSG_W(MSG_W), .FAST_W(FAST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .out_valid(out_valid), .out_lane(out_lane),
  .out_data(out_data), .lane_full(lane_full), .hold_v(hold_v), .grant(grant)
);

// File: tb/link_steer_test.sv
module link_steer_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   in_kind;
  logic         in_crit;
  logic [127:0] in_data;
  logic         out_valid;
  logic [1:0]   out_lane;
  logic [127:0] out_data;

  always #2 clk = ~clk;

  link_steer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_crit(in_crit), .in_data(in_data),
    .out_valid(out_valid), .out_lane(out_lane), .out_data(out_data)
  );

  typedef struct packed {
    logic [1:0]   k;
    logic         c;
    logic [127:0] d;
    logic [127:0] exp;
    logic [1:0]   ln;
    logic [7:0]   lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 128'hDEAD0000_00000000_00000000_00000042, 128'h42, 2'd0, 8'd2},
    '{2'd0, 1'b1, 128'hFF, 128'hFF, 2'd0, 8'd2},
    '{2'd0, 1'b1, 128'h100, 128'h100, 2'd1, 8'd3},
    '{2'd0, 1'b1, 128'hFFFF0000_00000000_12345678_9ABCDEF0, 128'h12345678_9ABCDEF0, 2'd1, 8'd3},
    '{2'd1, 1'b1, 128'hABCD, 128'hCD, 2'd0, 8'd2},
    '{2'd1, 1'b0, 128'h12345678, 128'h78, 2'd0, 8'd2},
    '{2'd0, 1'b0, 128'h99990000_00000000_00000000_55550000, 128'h55550000, 2'd2, 8'd4},
    '{2'd3, 1'b1, 128'h01234567_89ABCDEF_FEDCBA98_76543210, 128'h01234567_89ABCDEF_FEDCBA98_76543210, 2'd1, 8'd5},
    '{2'd3, 1'b0, 128'hCAFEF00D_11112222_33334444_55556666, 128'hCAFEF00D_11112222_33334444_55556666, 2'd2, 8'd4},
    '{2'd2, 1'b1, 128'h0BADBEEF_77778888_9999AAAA_BBBBCCCC, 128'h0BADBEEF_77778888_9999AAAA_BBBBCCCC, 2'd2, 8'd4},
    '{2'd0, 1'b0, 128'h7, 128'h7, 2'd0, 8'd2}
  };

  int chk_n  = 0;
  int fail_n = 0;
  int cyc    = 0;
  logic stall_seen = 1'b0;

  logic [127:0] rec_data [64];
  logic [1:0]   rec_lane [64];
  int           rec_t    [64];
  int           rec_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && rec_n < 64) begin
      rec_data[rec_n] = out_data;
      rec_lane[rec_n] = out_lane;
      rec_t[rec_n]    = cyc;
      rec_n           = rec_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic c, input logic [127:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_crit = c; in_data = d;
    while (!in_ready) begin
      stall_seen = 1'b1;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    chk_n++;
    fail_n++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  end

  initial begin
    int n, b;
    bit ok, any_base;
    logic [127:0] prev0, prev1;
    rst_n = 1'b0; in_valid = 1'b0; in_kind = '0; in_crit = 1'b0; in_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11 out_valid", 128'(out_valid), 128'h0);
    check(in_ready == 1'b1, "R11 in_ready", 128'(in_ready), 128'h1);
    rst_n = 1'b1;
    wait_idle(4);

    // R1 R2 R3 R4 R5 R6: table walk
    for (int v = 0; v < NV; v++) begin
      send(VECS[v].k, VECS[v].c, VECS[v].d);
      n = 0;
      do begin
        @(posedge clk); n++;
        @(negedge clk);
      end while (!out_valid && n < 40);
      check(out_lane == VECS[v].ln, $sformatf("R1/R2/R3 lane vec%0d", v), 128'(out_lane), 128'(VECS[v].ln));
      check(out_data == VECS[v].exp, $sformatf("R4/R5 payload vec%0d", v), out_data, VECS[v].exp);
      check(n == int'(VECS[v].lat), $sformatf("R6 latency vec%0d", v), 128'(n), 128'(VECS[v].lat));
      wait_idle(3);
    end

    // R7 R9: critical narrow burst overflows lane 0, falls back to lane 1
    b = rec_n;
    for (int i = 0; i < 12; i++) send(2'd0, 1'b1, 128'(i + 1));
    wait_idle(100);
    check(rec_n - b == 12, "R7 burst count", 128'(rec_n - b), 128'd12);
    any_base = 1'b0; ok = 1'b1; prev0 = '0; prev1 = '0;
    for (int i = b; i < rec_n; i++) begin
      if (rec_lane[i] == 2'd1) begin
        any_base = 1'b1;
        if (rec_data[i] <= prev1) ok = 1'b0;
        prev1 = rec_data[i];
      end else if (rec_lane[i] == 2'd0) begin
        if (rec_data[i] <= prev0) ok = 1'b0;
        prev0 = rec_data[i];
      end else ok = 1'b0;
    end
    check(any_base, "R7 fallback to lane 1", 128'(any_base), 128'h1);
    check(ok, "R9 per-lane order (fallback burst)", 128'(ok), 128'h1);

    // R8 R9: non-critical control burst stalls, all on lane 0 in order
    b = rec_n; stall_seen = 1'b0;
    for (int i = 0; i < 12; i++) send(2'd1, 1'b0, 128'(8'h20 + i));
    wait_idle(100);
    check(stall_seen, "R8 stall seen", 128'(stall_seen), 128'h1);
    check(rec_n - b == 12, "R8 no loss", 128'(rec_n - b), 128'd12);
    ok = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (rec_lane[b+i] != 2'd0 || rec_data[b+i] != 128'(8'h20 + i)) ok = 1'b0;
    end
    check(ok, "R9 lane 0 order", 128'(ok), 128'h1);

    // R10: lane 1 and lane 0 complete together, lane 0 first
    b = rec_n;
    send(2'd0, 1'b1, 128'h4444);
    send(2'd0, 1'b1, 128'h33);
    wait_idle(20);
    check(rec_n - b == 2, "R10 both delivered", 128'(rec_n - b), 128'd2);
    check(rec_lane[b] == 2'd0, "R10 first lane", 128'(rec_lane[b]), 128'd0);
    check(rec_lane[b+1] == 2'd1, "R10 second lane", 128'(rec_lane[b+1]), 128'd1);
    check(rec_t[b+1] == rec_t[b] + 1, "R10 next cycle", 128'(rec_t[b+1] - rec_t[b]), 128'd1);
    check(rec_data[b+1] == 128'h4444, "R10 held data", rec_data[b+1], 128'h4444);

    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  end
endmodule